// File: doc/BRIEF.md
# Core Test Wrapper with Boundary Cells

This block surrounds the functional terminals of an embedded core so the core can be tested on its own and the logic around it can be tested without the core. Every core input and every core output passes through a boundary cell. Each cell has a shift stage and a separate update stage. All the shift stages are linked into one serial boundary register. A one-bit bypass register gives a short serial path, so several wrappers can be daisy-chained on one serial line.

A three-bit instruction register sets the mode: transparent, inward-facing core test, outward-facing interconnect test, preload, clamp or safe. It is loaded through the same single-bit serial input while an instruction-select input is high. The test controller drives one strobe per cycle: shift, capture, update or transfer. Because outputs that are under test come from the update stages, shifting never disturbs the values the core or its neighbours see.

Top module: `ctw_wrap`

## Requirements
- R1: After reset the active instruction is 000 (transparent), every shift and update stage holds 0, and `ser_out` is 0.
- R2: While `sel_instr` is high, a shift moves the instruction shift stage one place toward `ser_out`, which shows its bit 0, and `ser_in` enters bit 2. A capture loads the active instruction into the shift stage. The active instruction changes only on an update strobe with `sel_instr` high.
- R3: Instruction codes are 000 transparent, 001 inward test, 010 outward test, 011 preload, 100 clamp and 101 safe. The codes 110 and 111 act as 000.
- R4: In transparent mode `core_in` equals `sys_in` and `sys_out` equals `core_out`. The serial path is the one-bit bypass: `ser_out` equals `ser_in` one shift later, and a capture clears it to 0.
- R5: Codes 001, 010 and 011 select the boundary register of N_IN+N_OUT cells. Cells 0 to N_IN-1 sit on the core inputs (cell i on bit i), and the cells above them sit on the core outputs. `ser_in` enters the top cell and `ser_out` shows cell 0, so the first bit shifted in reaches cell 0 after N_IN+N_OUT shifts.
- R6: In inward test mode, `core_in` comes from the update stages of the input cells and `sys_out` is SAFE_OUT. A capture loads `core_out` into the output cells and leaves the input cells unchanged.
- R7: In outward test mode, `sys_out` comes from the update stages of the output cells and `core_in` is SAFE_IN. A capture loads `sys_in` into the input cells and leaves the output cells unchanged.
- R8: In preload mode the functional paths stay transparent. A capture samples both `sys_in` and `core_out`, and an update loads the update stages.
- R9: In clamp mode both `core_in` and `sys_out` come from the update stages, and the serial path is the bypass.
- R10: In safe mode `core_in` is SAFE_IN and `sys_out` is SAFE_OUT, and the serial path is the bypass.
- R11: Update stages change only on an update strobe while the boundary register is selected. Shift, capture and transfer leave them unchanged.
- R12: A transfer strobe with the boundary register selected moves every cell one place toward `ser_out` in one cycle. Cell 0 wraps into the top cell, and `ser_in` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_in | input | 1 | Serial test data input |
| ser_out | output | 1 | Serial test data output |
| sel_instr | input | 1 | Routes serial access to the instruction register |
| shift_en | input | 1 | Shift strobe |
| capture_en | input | 1 | Capture strobe |
| update_en | input | 1 | Update strobe |
| transfer_en | input | 1 | Transfer (rotate) strobe |
| sys_in | input | N_IN | Signals arriving from the surrounding logic |
| core_in | output | N_IN | Signals driven into the core inputs |
| core_out | input | N_OUT | Signals leaving the core outputs |
| sys_out | output | N_OUT | Signals driven to the surrounding logic |

## Verification
The assertions assume that at most one of the shift, capture, update and transfer strobes is high in any cycle; one property checks this at the inputs. The bench never raises more than one strobe at a time. Each strobe lasts exactly one clock, and `sel_instr` and `ser_in` change only between strobes. Under that assumption the properties can tie each register change to a single event.

// File: rtl/ctw_pkg.sv
package ctw_pkg;
  localparam int IR_W = 3;

  typedef enum logic [IR_W-1:0] {
    OP_THRU  = 3'b000,
    OP_INW   = 3'b001,
    OP_OUTW  = 3'b010,
    OP_PRE   = 3'b011,
    OP_CLAMP = 3'b100,
    OP_SAFE  = 3'b101
  } op_e;

  // true when the code routes serial data through the boundary register
  function automatic logic uses_bsr(input logic [IR_W-1:0] code);
    return (code == OP_INW) || (code == OP_OUTW) || (code == OP_PRE);
  endfunction
endpackage

// File: rtl/ctw_ireg.sv
module ctw_ireg
  import ctw_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            sel,
  input  logic            shift_en,
  input  logic            capture_en,
  input  logic            update_en,
  input  logic            ser_in,
  output logic [IR_W-1:0] act_q,
  output logic            so
);
  logic [IR_W-1:0] sh_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q  <= '0;
      act_q <= '0;
    end else if (sel) begin
      if (shift_en)        sh_q <= {ser_in, sh_q[IR_W-1:1]};
      else if (capture_en) sh_q <= act_q;
      if (update_en)       act_q <= sh_q;
    end
  end

  assign so = sh_q[0];
endmodule

// File: rtl/ctw_bypass.sv
module ctw_bypass (
  input  logic clk,
  input  logic rst,
  input  logic shift_en,
  input  logic capture_en,
  input  logic ser_in,
  output logic q
);
  always_ff @(posedge clk) begin
    if (rst)             q <= 1'b0;
    else if (shift_en)   q <= ser_in;
    else if (capture_en) q <= 1'b0;
  end
endmodule

// File: rtl/ctw_bcell.sv
module ctw_bcell (
  input  logic clk,
  input  logic rst,
  input  logic move_en,
  input  logic move_d,
  input  logic cap_en,
  input  logic cap_d,
  input  logic upd_en,
  output logic sh_q,
  output logic upd_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q  <= 1'b0;
      upd_q <= 1'b0;
    end else begin
      if (move_en)     sh_q <= move_d;
      else if (cap_en) sh_q <= cap_d;
      if (upd_en)      upd_q <= sh_q;
    end
  end
endmodule

// File: rtl/ctw_wrap.sv
module ctw_wrap
  import ctw_pkg::*;
#(
  parameter int              N_IN     = 4,
  parameter int              N_OUT    = 4,
  parameter logic [N_IN-1:0]  SAFE_IN  = '0,
  parameter logic [N_OUT-1:0] SAFE_OUT = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ser_in,
  output logic             ser_out,
  input  logic             sel_instr,
  input  logic             shift_en,
  input  logic             capture_en,
  input  logic             update_en,
  input  logic             transfer_en,
  input  logic [N_IN-1:0]  sys_in,
  output logic [N_IN-1:0]  core_in,
  input  logic [N_OUT-1:0] core_out,
  output logic [N_OUT-1:0] sys_out
);
  localparam int L = N_IN + N_OUT;

  logic [IR_W-1:0] ir_act;
  logic            ir_so;
  logic            byp_q;
  logic            bsr_mode, use_bsr, use_byp;
  logic            mv_en, cap_lo, cap_hi, upd_b;
  logic [L-1:0]    bsr_sh, bsr_upd, mv_d, cap_d;

  ctw_ireg u_ir (
    .clk(clk), .rst(rst), .sel(sel_instr), .shift_en(shift_en),
    .capture_en(capture_en), .update_en(update_en), .ser_in(ser_in),
    .act_q(ir_act), .so(ir_so)
  );

  assign bsr_mode = uses_bsr(ir_act);
  assign use_bsr  = !sel_instr && bsr_mode;
  assign use_byp  = !sel_instr && !bsr_mode;

  ctw_bypass u_byp (
    .clk(clk), .rst(rst), .shift_en(use_byp && shift_en),
    .capture_en(use_byp && capture_en), .ser_in(ser_in), .q(byp_q)
  );

  assign mv_en  = use_bsr && (shift_en || transfer_en);
  assign cap_lo = use_bsr && capture_en && (ir_act == OP_OUTW || ir_act == OP_PRE);
  assign cap_hi = use_bsr && capture_en && (ir_act == OP_INW  || ir_act == OP_PRE);
  assign upd_b  = use_bsr && update_en;
  assign cap_d  = {core_out, sys_in};

  assign mv_d[L-1] = transfer_en ? bsr_sh[0] : ser_in;
  if (L > 1) begin : g_chain
    assign mv_d[L-2:0] = bsr_sh[L-1:1];
  end

  for (genvar i = 0; i < L; i++) begin : g_cell
    ctw_bcell u_cell (
      .clk(clk), .rst(rst),
      .move_en(mv_en), .move_d(mv_d[i]),
      .cap_en((i < N_IN) ? cap_lo : cap_hi), .cap_d(cap_d[i]),
      .upd_en(upd_b),
      .sh_q(bsr_sh[i]), .upd_q(bsr_upd[i])
    );
  end

  always_comb begin
    if (sel_instr)     ser_out = ir_so;
    else if (bsr_mode) ser_out = bsr_sh[0];
    else               ser_out = byp_q;
  end

  always_comb begin
    core_in = sys_in;
    sys_out = core_out;
    case (ir_act)
      OP_INW:   begin core_in = bsr_upd[N_IN-1:0]; sys_out = SAFE_OUT;           end
      OP_OUTW:  begin core_in = SAFE_IN;           sys_out = bsr_upd[L-1:N_IN]; end
      OP_CLAMP: begin core_in = bsr_upd[N_IN-1:0]; sys_out = bsr_upd[L-1:N_IN]; end
      OP_SAFE:  begin core_in = SAFE_IN;           sys_out = SAFE_OUT;           end
      default:  ;
    endcase
  end
endmodule

// File: rtl/ctw_wrap_chk.sv
module ctw_wrap_chk
  import ctw_pkg::*;
#(
  parameter int              N_IN     = 4,
  parameter int              N_OUT    = 4,
  parameter logic [N_IN-1:0]  SAFE_IN  = '0,
  parameter logic [N_OUT-1:0] SAFE_OUT = '0
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    ser_in,
  input logic                    ser_out,
  input logic                    sel_instr,
  input logic                    shift_en,
  input logic                    capture_en,
  input logic                    update_en,
  input logic                    transfer_en,
  input logic [N_IN-1:0]         sys_in,
  input logic [N_IN-1:0]         core_in,
  input logic [N_OUT-1:0]        core_out,
  input logic [N_OUT-1:0]        sys_out,
  input logic [IR_W-1:0]         ir_act,
  input logic [N_IN+N_OUT-1:0]   bsr_sh,
  input logic [N_IN+N_OUT-1:0]   bsr_upd
);
  localparam int L = N_IN + N_OUT;

  // input assumption: one strobe per cycle
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $countones({shift_en, capture_en, update_en, transfer_en}) <= 1);

  // R2
  ir_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(update_en && sel_instr) |=> $stable(ir_act));

  // R4
  thru_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (ir_act == OP_THRU) |-> (core_in == sys_in && sys_out == core_out));

  // R4
  byp_delay_chk: assert property (@(posedge clk) disable iff (rst)
    (ir_act == OP_THRU && !sel_instr && shift_en) |=> (sel_instr || ser_out == $past(ser_in)));

  // R6
  inw_drive_chk: assert property (@(posedge clk) disable iff (rst)
    (ir_act == OP_INW) |-> (core_in == bsr_upd[N_IN-1:0] && sys_out == SAFE_OUT));

  // R10
  safe_drive_chk: assert property (@(posedge clk) disable iff (rst)
    (ir_act == OP_SAFE) |-> (core_in == SAFE_IN && sys_out == SAFE_OUT));

  // R11
  upd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !update_en |=> $stable(bsr_upd));

  // R12
  xfer_rot_chk: assert property (@(posedge clk) disable iff (rst)
    (transfer_en && !sel_instr && uses_bsr(ir_act))
      |=> (bsr_sh == {$past(bsr_sh[0]), $past(bsr_sh[L-1:1])}));
endmodule

bind ctw_wrap ctw_wrap_chk #(
  .N_IN(N_IN), .N_OUT(N_OUT), .SAFE_IN(SAFE_IN), .SAFE_OUT(SAFE_OUT)
) chk_i (
  .clk(clk), .rst(rst), .ser_in(ser_in), .ser_out(ser_out),
  .sel_instr(sel_instr), .shift_en(shift_en), .capture_en(capture_en),
  .update_en(update_en), .transfer_en(transfer_en),
  .sys_in(sys_in), .core_in(core_in), .core_out(core_out), .sys_out(sys_out),
  .ir_act(ir_act), .bsr_sh(bsr_sh), .bsr_upd(bsr_upd)
);

// File: tb/ctw_wrap_tb_top.sv
module ctw_wrap_tb_top;
  localparam int NI = 4;
  localparam int NO = 4;
  localparam logic [NI-1:0] S_IN  = 4'b1001;
  localparam logic [NO-1:0] S_OUT = 4'b0110;

  // {code, sys_in, core_out, exp core_in, exp sys_out}; update stages: in=1100, out=0011
  localparam logic [18:0] VEC [8] = '{
    {3'b000, 4'b0101, 4'b1110, 4'b0101, 4'b1110},
    {3'b001, 4'b0110, 4'b0001, 4'b1100, 4'b0110},
    {3'b010, 4'b0111, 4'b1000, 4'b1001, 4'b0011},
    {3'b011, 4'b1010, 4'b0100, 4'b1010, 4'b0100},
    {3'b100, 4'b1111, 4'b0000, 4'b1100, 4'b0011},
    {3'b101, 4'b0000, 4'b1111, 4'b1001, 4'b0110},
    {3'b110, 4'b1011, 4'b1101, 4'b1011, 4'b1101},
    {3'b111, 4'b0010, 4'b0111, 4'b0010, 4'b0111}
  };

  logic clk = 1'b0, rst = 1'b1;
  logic ser_in = 1'b0, ser_out, sel_instr = 1'b0;
  logic shift_en = 1'b0, capture_en = 1'b0, update_en = 1'b0, transfer_en = 1'b0;
  logic [NI-1:0] sys_in = '0, core_in;
  logic [NO-1:0] core_out = '0, sys_out;
  int checks = 0, errors = 0;
  logic [7:0] rd;

  always #4 clk = ~clk;

  ctw_wrap #(.N_IN(NI), .N_OUT(NO), .SAFE_IN(S_IN), .SAFE_OUT(S_OUT)) dut_i (
    .clk(clk), .rst(rst), .ser_in(ser_in), .ser_out(ser_out),
    .sel_instr(sel_instr), .shift_en(shift_en), .capture_en(capture_en),
    .update_en(update_en), .transfer_en(transfer_en),
    .sys_in(sys_in), .core_in(core_in), .core_out(core_out), .sys_out(sys_out)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic strobe(input logic sh, input logic cap, input logic up, input logic xf);
    shift_en = sh; capture_en = cap; update_en = up; transfer_en = xf;
    @(negedge clk);
    shift_en = 0; capture_en = 0; update_en = 0; transfer_en = 0;
  endtask

  task automatic load_ir(input logic [2:0] code);
    sel_instr = 1;
    for (int i = 0; i < 3; i++) begin ser_in = code[i]; strobe(1, 0, 0, 0); end
    strobe(0, 0, 1, 0);
    sel_instr = 0;
  endtask

  // shifts 8 bits in (bit 0 first) and returns what came out, cell 0 first
  task automatic shift_bsr(input logic [7:0] din, output logic [7:0] dout);
    for (int i = 0; i < 8; i++) begin
      dout[i] = ser_out;
      ser_in = din[i];
      strobe(1, 0, 0, 0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    sys_in = 4'b0101; core_out = 4'b1010;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    check("R1 core_in", 8'(core_in), 8'(4'b0101));
    check("R1 sys_out", 8'(sys_out), 8'(4'b1010));
    check("R1 ser_out", 8'(ser_out), 8'h0);

    // preload update stages with in=1100, out=0011
    load_ir(3'b011);
    shift_bsr(8'b0011_1100, rd);
    strobe(0, 0, 1, 0);

    // R3 table walk over every code
    foreach (VEC[k]) begin
      load_ir(VEC[k][18:16]);
      sys_in = VEC[k][15:12]; core_out = VEC[k][11:8];
      @(negedge clk);
      check($sformatf("R3 code%0d core_in", k), 8'(core_in), 8'(VEC[k][7:4]));
      check($sformatf("R3 code%0d sys_out", k), 8'(sys_out), 8'(VEC[k][3:0]));
    end

    // R2 capture/readback and delayed effect
    load_ir(3'b010);
    sel_instr = 1;
    strobe(0, 1, 0, 0);
    for (int i = 0; i < 3; i++) begin
      rd[i] = ser_out; ser_in = (i != 1); strobe(1, 0, 0, 0);
    end
    check("R2 readback", {5'b0, rd[2:0]}, 8'h02);
    check("R2 no update yet", 8'(sys_out), 8'(4'b0011));
    strobe(0, 0, 1, 0);
    sel_instr = 0;
    check("R2 after update", 8'({core_in, sys_out}), 8'({S_IN, S_OUT}));

    // R4 bypass path
    load_ir(3'b000);
    ser_in = 1; strobe(1, 0, 0, 0);
    check("R4 bypass one", 8'(ser_out), 8'h1);
    strobe(0, 1, 0, 0);
    check("R4 bypass capture", 8'(ser_out), 8'h0);

    // R5 length, order and cell position
    load_ir(3'b001);
    shift_bsr(8'h01, rd);
    shift_bsr(8'h5A, rd);
    check("R5 shift through", rd, 8'h01);
    shift_bsr(8'h01, rd);
    strobe(0, 0, 1, 0);
    check("R5 cell0 on core_in[0]", 8'(core_in), 8'h01);

    // R6 inward capture
    shift_bsr(8'h5A, rd);
    core_out = 4'b1011; sys_in = 4'b0000;
    strobe(0, 1, 0, 0);
    shift_bsr(8'h00, rd);
    check("R6 inward capture", rd, 8'hBA);

    // R7 outward capture
    load_ir(3'b010);
    shift_bsr(8'h5A, rd);
    sys_in = 4'b0111; core_out = 4'b0000;
    strobe(0, 1, 0, 0);
    shift_bsr(8'h00, rd);
    check("R7 outward capture", rd, 8'h57);

    // R11 update stage holds while shifting
    shift_bsr(8'h3C, rd);
    strobe(0, 0, 1, 0);
    check("R11 after update", 8'(sys_out), 8'(4'b0011));
    for (int i = 0; i < 8; i++) begin
      ser_in = 1; strobe(1, 0, 0, 0);
      if (i == 7) check("R11 hold during shift", 8'(sys_out), 8'(4'b0011));
    end
    strobe(0, 1, 0, 0);
    check("R11 hold after capture", 8'(sys_out), 8'(4'b0011));
    strobe(0, 0, 1, 0);
    check("R11 update applies", 8'(sys_out), 8'(4'b1111));

    // R8 preload samples both sides, stays transparent
    load_ir(3'b011);
    sys_in = 4'b0011; core_out = 4'b1100;
    strobe(0, 1, 0, 0);
    check("R8 transparent", 8'({core_in, sys_out}), 8'h3C);
    shift_bsr(8'h00, rd);
    check("R8 preload capture", rd, 8'hC3);

    // R9 clamp uses bypass, holds update values
    strobe(0, 0, 1, 0);
    load_ir(3'b100);
    ser_in = 1; strobe(1, 0, 0, 0);
    check("R9 clamp bypass", 8'(ser_out), 8'h1);
    check("R9 clamp outputs", 8'({core_in, sys_out}), 8'h00);

    // R10 safe uses bypass
    load_ir(3'b101);
    ser_in = 0; strobe(1, 0, 0, 0);
    check("R10 safe bypass", 8'(ser_out), 8'h0);
    check("R10 safe outputs", 8'({core_in, sys_out}), 8'({S_IN, S_OUT}));

    // R12 transfer rotates toward ser_out, ignores ser_in
    load_ir(3'b001);
    shift_bsr(8'h03, rd);
    ser_in = 0;
    strobe(0, 0, 0, 1);
    shift_bsr(8'h00, rd);
    check("R12 transfer rotate", rd, 8'h81);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule